// File: doc/BRIEF.md
# Eight-Bit Signed Saturating ALU with Condition Flags

This block is a clocked arithmetic unit for two 8-bit two's-complement operands. A 4-bit opcode, qualified by a valid strobe, picks one of seven arithmetic functions:

- addition or subtraction that wrap modulo 256;
- addition or subtraction that clamp to the signed range;
- an absolute value of A, of A+B or of A-B, clamped to +127.

The result and three condition flags sit in registers and change on the clock edge that samples the command.

The negative and zero flags describe the last result that was written. The saturation flag is sticky. Any clamping operation sets it, and it stays set until a dedicated clear opcode or reset. Software can therefore run a whole series of operations and test for overflow once at the end. A no-operation code, the unused codes and an idle strobe leave every register as it was.

Internally the operands are sign-extended by two guard bits before the single adder. The absolute value of a difference such as 127-(-128) = 255, or of a sum such as -128+-128 = -256, is therefore exact before the clamp is applied.

Top module: `sat_alu8`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become result = 0, `flag_n` = 0, `flag_z` = 1 and `flag_s` = 0.
- R2: Opcode 1 with `in_valid` writes (A+B) mod 256 to `result` on the next edge and never sets `flag_s`.
- R3: Opcode 2 with `in_valid` writes (A-B) mod 256 to `result` and never sets `flag_s`.
- R4: Opcode 3 writes A+B clamped to the range -128..+127, and sets `flag_s` when the clamp acts.
- R5: Opcode 4 writes A-B clamped to the range -128..+127, and sets `flag_s` when the clamp acts.
- R6: Opcode 5 writes |A|. A = -128 yields +127 and sets `flag_s`.
- R7: Opcodes 6 and 7 write |A+B| and |A-B|. Any magnitude above 127 yields +127 and sets `flag_s`.
- R8: Opcodes 1 to 7 set `flag_n` to bit 7 of the written result and set `flag_z` to 1 exactly when the written result is zero. At all times `flag_n` equals bit 7 of `result`, and `flag_z` equals (`result` == 0).
- R9: `flag_s` is sticky. Once set, only opcode 8 or reset clears it. A non-clamping operation leaves it as it was.
- R10: Opcode 8 with `in_valid` clears `flag_s` and leaves `result`, `flag_n` and `flag_z` unchanged.
- R11: Opcode 0, opcodes 9 to 15, or `in_valid` low leave `result` and all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies opcode and operands for this cycle |
| opcode | input | 4 | Operation select (0..15) |
| a | input | 8 | Operand A, two's complement |
| b | input | 8 | Operand B, two's complement |
| result | output | 8 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sticky saturation flag |

## Verification
The assertions check, on every cycle, the rules that involve only the flags and the register contents:
- idle and unused codes hold every output;
- the clear code drops the saturation flag and touches nothing else;
- the saturation flag stays set, and the wrapping codes never raise it;
- the negative and zero flags agree with the stored result;
- an absolute-value result is never negative;
- a fresh saturation on an add or subtract leaves one of the two range limits in the register.

Only the bench's sweeps can show that each arithmetic function returns the right value, and that the clamp acts at exactly the right operand pairs. The bench runs every value of A against a stride of B values for each opcode, plus the extreme corners, and compares against integer arithmetic.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_IDLE    = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ADD_W   = 4'd1;
  localparam logic [OPC_W-1:0] OPC_SUB_W   = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD_S   = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SUB_S   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_ABS_A   = 4'd5;
  localparam logic [OPC_W-1:0] OPC_ABS_SUM = 4'd6;
  localparam logic [OPC_W-1:0] OPC_ABS_DIF = 4'd7;
  localparam logic [OPC_W-1:0] OPC_CLR_SAT = 4'd8;

  typedef enum logic [1:0] {
    MODE_WRAP = 2'd0,
    MODE_CLAMP = 2'd1,
    MODE_MAG = 2'd2
  } post_mode_e;

  typedef struct packed {
    logic       use_b;
    logic       inv_b;
    post_mode_e mode;
    logic       writes;
    logic       clr_sat;
  } op_ctrl_t;

endpackage

// File: rtl/sat_alu_decode.sv
module sat_alu_decode
  import sat_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_ctrl_t         ctrl
);

  always_comb begin
    ctrl = '{use_b: 1'b1, inv_b: 1'b0, mode: MODE_WRAP, writes: 1'b0, clr_sat: 1'b0};
    case (opcode)
      OPC_ADD_W: begin
        ctrl.writes = 1'b1;
      end
      OPC_SUB_W: begin
        ctrl.inv_b  = 1'b1;
        ctrl.writes = 1'b1;
      end
      OPC_ADD_S: begin
        ctrl.mode   = MODE_CLAMP;
        ctrl.writes = 1'b1;
      end
      OPC_SUB_S: begin
        ctrl.inv_b  = 1'b1;
        ctrl.mode   = MODE_CLAMP;
        ctrl.writes = 1'b1;
      end
      OPC_ABS_A: begin
        ctrl.use_b  = 1'b0;
        ctrl.mode   = MODE_MAG;
        ctrl.writes = 1'b1;
      end
      OPC_ABS_SUM: begin
        ctrl.mode   = MODE_MAG;
        ctrl.writes = 1'b1;
      end
      OPC_ABS_DIF: begin
        ctrl.inv_b  = 1'b1;
        ctrl.mode   = MODE_MAG;
        ctrl.writes = 1'b1;
      end
      OPC_CLR_SAT: begin
        ctrl.clr_sat = 1'b1;
      end
      default: begin
        ctrl.writes = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sat_alu_preproc.sv
module sat_alu_preproc
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GUARD_W = 2,
  localparam int EXT_W = DATA_W + GUARD_W
) (
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  input  op_ctrl_t                ctrl,
  output logic signed [EXT_W-1:0] sum
);

  logic [EXT_W-1:0] opa_ext;
  logic [EXT_W-1:0] opb_ext;
  logic [EXT_W-1:0] opb_sel;
  logic [EXT_W-1:0] cin_ext;

  assign opa_ext = {{GUARD_W{a[DATA_W-1]}}, a};
  assign opb_ext = {{GUARD_W{b[DATA_W-1]}}, b};

  always_comb begin
    if (!ctrl.use_b) begin
      opb_sel = '0;
    end else if (ctrl.inv_b) begin
      opb_sel = ~opb_ext;
    end else begin
      opb_sel = opb_ext;
    end
  end

  // Carry-in of one finishes the two's-complement negation of B.
  assign cin_ext = {{(EXT_W-1){1'b0}}, ctrl.use_b & ctrl.inv_b};
  assign sum = $signed(opa_ext + opb_sel + cin_ext);

endmodule

// File: rtl/sat_alu_postproc.sv
module sat_alu_postproc
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GUARD_W = 2,
  localparam int EXT_W = DATA_W + GUARD_W,
  localparam int POS_LIM = (1 << (DATA_W - 1)) - 1
) (
  input  logic signed [EXT_W-1:0] sum,
  input  post_mode_e              mode,
  output logic [DATA_W-1:0]       res,
  output logic                    sat
);

  localparam logic signed [EXT_W-1:0] HI_EXT = EXT_W'(POS_LIM);
  localparam logic signed [EXT_W-1:0] LO_EXT = -HI_EXT - EXT_W'(1);
  localparam logic [DATA_W-1:0] HI_RES = DATA_W'(POS_LIM);
  localparam logic [DATA_W-1:0] LO_RES = ~HI_RES;

  logic [EXT_W-1:0] mag;
  logic             mag_big;
  logic             over_hi;
  logic             under_lo;

  assign mag      = sum[EXT_W-1] ? (~sum + EXT_W'(1)) : sum;
  assign mag_big  = (mag > HI_EXT);
  assign over_hi  = (sum > HI_EXT);
  assign under_lo = (sum < LO_EXT);

  always_comb begin
    res = sum[DATA_W-1:0];
    sat = 1'b0;
    case (mode)
      MODE_CLAMP: begin
        if (over_hi) begin
          res = HI_RES;
          sat = 1'b1;
        end else if (under_lo) begin
          res = LO_RES;
          sat = 1'b1;
        end
      end
      MODE_MAG: begin
        if (mag_big) begin
          res = HI_RES;
          sat = 1'b1;
        end else begin
          res = mag[DATA_W-1:0];
        end
      end
      default: begin
        res = sum[DATA_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/sat_alu8.sv
module sat_alu8
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GUARD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_s
);

  localparam int EXT_W = DATA_W + GUARD_W;

  op_ctrl_t                ctrl;
  logic signed [EXT_W-1:0] sum;
  logic [DATA_W-1:0]       res_nxt;
  logic                    sat_nxt;

  sat_alu_decode u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  sat_alu_preproc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_pre (
    .a    (a),
    .b    (b),
    .ctrl (ctrl),
    .sum  (sum)
  );

  sat_alu_postproc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_post (
    .sum  (sum),
    .mode (ctrl.mode),
    .res  (res_nxt),
    .sat  (sat_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b1;
      flag_s <= 1'b0;
    end else if (in_valid) begin
      if (ctrl.writes) begin
        result <= res_nxt;
        flag_n <= res_nxt[DATA_W-1];
        flag_z <= (res_nxt == '0);
        flag_s <= flag_s | sat_nxt;
      end else if (ctrl.clr_sat) begin
        flag_s <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sat_alu8_chk.sv
module sat_alu8_chk #(
  parameter int DATA_W = 8,
  parameter int OPC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_s
);

  localparam logic [OPC_W-1:0] K_ADDW = OPC_W'(1);
  localparam logic [OPC_W-1:0] K_SUBW = OPC_W'(2);
  localparam logic [OPC_W-1:0] K_ADDS = OPC_W'(3);
  localparam logic [OPC_W-1:0] K_SUBS = OPC_W'(4);
  localparam logic [OPC_W-1:0] K_ABS0 = OPC_W'(5);
  localparam logic [OPC_W-1:0] K_ABS2 = OPC_W'(7);
  localparam logic [OPC_W-1:0] K_CLR  = OPC_W'(8);
  localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$past(in_valid) || $past(opcode) == '0 || $past(opcode) > K_CLR))
    |-> ($stable(result) && $stable(flag_n) && $stable(flag_z) && $stable(flag_s))); // R11

  AST_CLR_ONLY_S: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(opcode) == K_CLR)
    |-> (!flag_s && $stable(result) && $stable(flag_n) && $stable(flag_z))); // R10

  AST_S_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_s) && !($past(in_valid) && $past(opcode) == K_CLR))
    |-> flag_s); // R9

  AST_WRAP_NO_SAT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(flag_s)
     && ($past(opcode) == K_ADDW || $past(opcode) == K_SUBW))
    |-> !flag_s); // R9

  AST_NZ_AGREE: assert property (@(posedge clk) disable iff (rst)
    (flag_n == result[DATA_W-1]) && (flag_z == (result == '0))); // R8

  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(opcode) >= K_ABS0 && $past(opcode) <= K_ABS2)
    |-> !flag_n); // R6

  AST_CLAMP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(flag_s) && flag_s
     && ($past(opcode) == K_ADDS || $past(opcode) == K_SUBS))
    |-> (result == MAXV || result == MINV)); // R4

endmodule

bind sat_alu8 sat_alu8_chk #(.DATA_W(DATA_W), .OPC_W(sat_alu_pkg::OPC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .opcode   (opcode),
  .result   (result),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_s   (flag_s)
);

// File: tb/tb_sat_alu8.sv
`timescale 1ns/1ps
module tb_sat_alu8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] opcode = '0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic [7:0] result;
  logic       flag_n, flag_z, flag_s;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m_res = '0;
  logic       m_n = 1'b0, m_z = 1'b1, m_s = 1'b0;

  always #2 clk = ~clk;

  sat_alu8 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .a(a), .b(b), .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_s(flag_s)
  );

  function automatic string op_tag(input int op);
    case (op)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      8: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Expected {sat, value} from integer arithmetic.
  function automatic logic [8:0] model(input int op, input logic [7:0] ua, input logic [7:0] ub);
    int sa, sb, t;
    logic s;
    sa = $signed(ua);
    sb = $signed(ub);
    s = 1'b0;
    case (op)
      1: t = sa + sb;
      2: t = sa - sb;
      3, 4: begin
        t = (op == 3) ? sa + sb : sa - sb;
        if (t > 127) begin t = 127; s = 1'b1; end
        if (t < -128) begin t = -128; s = 1'b1; end
      end
      default: begin
        t = (op == 5) ? sa : (op == 6) ? sa + sb : sa - sb;
        if (t < 0) t = -t;
        if (t > 127) begin t = 127; s = 1'b1; end
      end
    endcase
    return {s, t[7:0]};
  endfunction

  task automatic compare(input string ctx);
    string tag;
    tests++;
    if (result !== m_res || flag_n !== m_n || flag_z !== m_z || flag_s !== m_s) begin
      fails++;
      if (result !== m_res) tag = ctx;
      else if (flag_n !== m_n || flag_z !== m_z) tag = "R8";
      else tag = "R9";
      $display("FAIL %s: got res=%0d n=%0b z=%0b s=%0b, expected res=%0d n=%0b z=%0b s=%0b",
               tag, result, flag_n, flag_z, flag_s, m_res, m_n, m_z, m_s);
    end
  endtask

  task automatic do_op(input int op, input logic [7:0] va, input logic [7:0] vb, input logic v);
    logic [8:0] e;
    @(negedge clk);
    in_valid = v;
    opcode = 4'(op);
    a = va;
    b = vb;
    @(posedge clk);
    #1;
    if (v && op >= 1 && op <= 7) begin
      e = model(op, va, vb);
      m_res = e[7:0];
      m_n = e[7];
      m_z = (e[7:0] == 8'd0);
      m_s = m_s | e[8];
    end else if (v && op == 8) begin
      m_s = 1'b0;
    end
    compare(v ? op_tag(op) : "R11");
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    compare("R1");
    @(negedge clk);
    rst = 1'b0;

    // R2 wrap without S, R4 clamp corners
    do_op(1, 8'd127, 8'd1, 1'b1);
    do_op(2, 8'h80, 8'd1, 1'b1);      // R3
    do_op(3, 8'd127, 8'd1, 1'b1);     // R4
    do_op(8, 8'd0, 8'd0, 1'b1);       // R10
    do_op(3, 8'h80, 8'hFF, 1'b1);     // R4 negative clamp
    do_op(8, 8'd0, 8'd0, 1'b1);
    do_op(4, 8'h80, 8'd1, 1'b1);      // R5
    do_op(2, 8'd5, 8'd5, 1'b1);       // R9: S stays set, Z from result
    do_op(8, 8'd0, 8'd0, 1'b1);
    do_op(5, 8'h80, 8'd0, 1'b1);      // R6 |-128| -> 127
    do_op(8, 8'd0, 8'd0, 1'b1);
    do_op(7, 8'd127, 8'h80, 1'b1);    // R7 255 -> 127
    do_op(8, 8'd0, 8'd0, 1'b1);
    do_op(6, 8'h80, 8'h80, 1'b1);     // R7 |-256| -> 127
    do_op(1, 8'hF0, 8'h01, 1'b1);     // R8 negative result
    // R11: idle and unused codes
    do_op(3, 8'd127, 8'd127, 1'b0);
    do_op(0, 8'd127, 8'd127, 1'b1);
    do_op(12, 8'd127, 8'd127, 1'b1);
    do_op(15, 8'h80, 8'h80, 1'b1);

    // Sweep: every A, B in steps of 7, all arithmetic opcodes.
    for (int op = 1; op <= 7; op++) begin
      for (int ia = 0; ia < 256; ia++) begin
        for (int ib = 0; ib < 256; ib += 7) begin
          if (m_s) do_op(8, 8'(ia), 8'(ib), 1'b1);
          do_op(op, 8'(ia), 8'(ib), 1'b1);
        end
      end
    end

    done = 1;
    summary();
  end

endmodule